// File: doc/BRIEF.md
# Configuration Clock Burst Generator

This block drives the configuration clock of a programmable fabric. Software starts a burst by writing a pulse count into a register. The block then emits exactly that many clock pulses on `cfg_dclk`. Each pulse is one system clock high followed by one system clock low. `cfg_dclk_en` is high for as long as the burst runs.

When the last pulse has been produced, the block raises a sticky completion flag. Software polls that flag and clears it by writing a one to it. A typical flow clears the flag, writes the count, polls until the flag is set, and clears the flag again.

The register slave uses a plain read/write strobe interface with 32-bit data on a 4-byte stride. There is no streaming data path, so the bus carries no valid/ready handshake. A write is taken in the cycle `wr_en` is high. Read data is combinational and valid in the cycle `rd_en` is high.

Top module: `cfg_dclk_burst`

## Requirements
- R1: After reset `cfg_dclk` and `cfg_dclk_en` are low, the count register reads 0 and the status register reads 0.
- R2: A write of N (N > 0) to byte offset 0x08 while idle produces exactly N pulses. The first pulse is high in the cycle after the write edge. Each pulse is high for one cycle and low for one cycle.
- R3: `cfg_dclk_en` is high from the write edge until the edge that ends the last high phase. `cfg_dclk` is low whenever `cfg_dclk_en` is low.
- R4: Status bit 0 at byte offset 0x0C (done) becomes 1 at the edge that ends the last pulse's high phase. It then stays 1 until software clears it.
- R5: A write to offset 0x0C with wdata bit 0 = 1 clears done. A write with bit 0 = 0 leaves done unchanged, whatever the other bits hold.
- R6: A write of 0 to the count register sets done at that write edge and produces no pulse.
- R7: A write to the count register while a burst is running is ignored. The pulse train and the remaining count continue unchanged.
- R8: Reading offset 0x08 returns the number of pulses not yet completed. The value is N right after the write and drops by one at each falling edge of `cfg_dclk`.
- R9: Only the word-aligned offsets 0x08 and 0x0C are decoded. Writes to any other address, including misaligned ones, have no effect. Reads there return 0. The upper 31 bits of a status read are 0.
- R10: The count uses the low CNT_W wdata bits (12 by default) and ignores the bits above them. Bursts of 256 and of 0x7FF pulses complete with the exact pulse count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, zero when `rd_en` is low |
| cfg_dclk | output | 1 | Configuration clock pulse output, idles low |
| cfg_dclk_en | output | 1 | High while a burst is being driven |

## Verification
The bound checker watches the following on every cycle:
- `cfg_dclk` never stays high for two cycles and stays low while the enable is off.
- Within a burst, every low phase is followed by a high phase.
- The remaining count drops by exactly one at each falling edge and holds during low phases, even under competing writes.
- Done stays set unless a clearing write arrives.
- A zero-count write sets done without starting a burst.

Some behaviours only the bench scenarios can show:
- The exact pulse totals for every count from 0 to 20 and for 256 and 0x7FF.
- The cycle in which done rises.
- The truncation of upper count bits.
- That writes to undecoded addresses leave all visible state untouched.

// File: rtl/cfgb_pkg.sv
`timescale 1ns/1ps
package cfgb_pkg;
  localparam int unsigned BUS_W = 32;
  localparam logic [7:0] OFS_COUNT  = 8'h08;
  localparam logic [7:0] OFS_STATUS = 8'h0C;
  typedef enum logic [1:0] {SEL_NONE, SEL_COUNT, SEL_STATUS} reg_sel_e;
endpackage

// File: rtl/cfgb_regdec.sv
`timescale 1ns/1ps
module cfgb_regdec
  import cfgb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  remaining,
  input  logic              done_q,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              stat_clr,
  output logic [BUS_W-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);

  reg_sel_e sel;
  logic     unused_hi;

  always_comb begin
    sel = SEL_NONE;
    if (addr == A_CNT)       sel = SEL_COUNT;
    else if (addr == A_STAT) sel = SEL_STATUS;
  end

  assign cnt_wr    = wr_en && (sel == SEL_COUNT);
  assign cnt_val   = wdata[CNT_W-1:0];
  assign stat_clr  = wr_en && (sel == SEL_STATUS) && wdata[0];
  assign unused_hi = ^wdata[BUS_W-1:CNT_W];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_COUNT:  rdata = {{(BUS_W-CNT_W){1'b0}}, remaining};
        SEL_STATUS: rdata = {{(BUS_W-1){1'b0}}, done_q};
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cfgb_pulse_eng.sv
`timescale 1ns/1ps
module cfgb_pulse_eng #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             dclk,
  output logic             busy,
  output logic [CNT_W-1:0] remaining,
  output logic             fin
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic last_fall, zero_start;

  assign last_fall  = busy && dclk && (remaining == ONE);
  assign zero_start = start && !busy && (load_val == '0);
  assign fin        = last_fall || zero_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      dclk      <= 1'b0;
      remaining <= '0;
    end else if (!busy) begin
      if (start) begin
        remaining <= load_val;
        if (load_val != '0) begin
          busy <= 1'b1;
          dclk <= 1'b1;
        end
      end
    end else if (dclk) begin
      dclk      <= 1'b0;
      remaining <= remaining - ONE;
      if (remaining == ONE) busy <= 1'b0;
    end else begin
      dclk <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgb_done_flag.sv
`timescale 1ns/1ps
module cfgb_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic done_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     done_q <= 1'b0;
    else if (set_i) done_q <= 1'b1;
    else if (clr_i) done_q <= 1'b0;
  end
endmodule

// File: rtl/cfg_dclk_burst.sv
`timescale 1ns/1ps
module cfg_dclk_burst
  import cfgb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              cfg_dclk,
  output logic              cfg_dclk_en
);
  logic             cnt_wr, stat_clr, busy, fin, done_q;
  logic [CNT_W-1:0] cnt_val, remaining;

  cfgb_regdec #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .remaining(remaining), .done_q(done_q),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val), .stat_clr(stat_clr), .rdata(rdata)
  );

  cfgb_pulse_eng #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(cnt_wr), .load_val(cnt_val),
    .dclk(cfg_dclk), .busy(busy), .remaining(remaining), .fin(fin)
  );

  cfgb_done_flag u_done (
    .clk(clk), .rst_n(rst_n), .set_i(fin), .clr_i(stat_clr), .done_q(done_q)
  );

  assign cfg_dclk_en = busy;
endmodule

// File: rtl/cfg_dclk_burst_chk.sv
`timescale 1ns/1ps
module cfg_dclk_burst_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              cfg_dclk,
  input logic              cfg_dclk_en,
  input logic              done_q,
  input logic [CNT_W-1:0]  rem
);
  logic unused_wd;
  logic cnt_hit, clr_hit;
  assign unused_wd = ^wdata[31:CNT_W];
  assign cnt_hit   = wr_en && (addr == ADDR_W'(8'h08));
  assign clr_hit   = wr_en && (addr == ADDR_W'(8'h0C)) && wdata[0];

  // R3
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dclk_en |-> !cfg_dclk);
  // R2
  high_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dclk |=> !cfg_dclk);
  // R2
  low_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dclk_en && !cfg_dclk) |=> cfg_dclk);
  // R7
  rem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dclk_en && !cfg_dclk) |=> $stable(rem));
  // R8
  rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dclk_en && cfg_dclk) |=> (rem == $past(rem) - CNT_W'(1)));
  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_hit) |=> done_q);
  // R6
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dclk_en && cnt_hit && (wdata[CNT_W-1:0] == '0)) |=> (done_q && !cfg_dclk_en));
endmodule

bind cfg_dclk_burst cfg_dclk_burst_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cfg_dclk(cfg_dclk), .cfg_dclk_en(cfg_dclk_en), .done_q(done_q), .rem(remaining)
);

// File: tb/cfg_dclk_burst_bench.sv
`timescale 1ns/1ps
module cfg_dclk_burst_bench;
  localparam int AW = 8;
  localparam int CW = 12;
  localparam logic [AW-1:0] A_CNT = 8'h08;
  localparam logic [AW-1:0] A_ST  = 8'h0C;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  wire  [31:0]   rdata;
  wire           dclk, den;
  int total = 0, bad = 0;

  cfg_dclk_burst #(.ADDR_W(AW), .CNT_W(CW)) u_cfg_dclk_burst (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cfg_dclk(dclk), .cfg_dclk_en(den)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata; rd_en = 1'b0;
  endtask

  // mode 0 reads the count every cycle, mode 1 reads the status
  task automatic run_burst(input int n, input logic [31:0] wval, input int mode,
                           input int mid_c, input string req);
    logic [31:0] d, fa, fe;
    int werr, rerr, pulses, wa, we;
    logic prev;
    werr = 0; rerr = 0; pulses = 0; prev = 1'b0; fa = '0; fe = '0; wa = 0; we = 0;
    bus_wr(A_ST, 32'h1);
    bus_rd(A_ST, d);
    chk(d == 0, "R5", "status after clear", d, 0);
    bus_wr(A_CNT, wval);
    for (int c = 0; c < 2*n + 3; c++) begin
      bit ed, een, edn;
      logic [31:0] er;
      if (c > 0) @(negedge clk);
      rd_en = 1'b1;
      addr  = (mode == 1) ? A_ST : A_CNT;
      wr_en = (c == mid_c);
      wdata = 32'd9;
      if (c == mid_c) addr = A_CNT;
      #1;
      ed  = (n > 0) && (c < 2*n) && (c % 2 == 0);
      een = (n > 0) && (c < 2*n - 1);
      edn = (n == 0) || (c >= 2*n - 1);
      er  = (c >= 2*n) ? 32'd0 : 32'(n - (c + 1) / 2);
      if (mode == 1) er = {31'd0, edn};
      if ({dclk, den} != {ed, een}) begin
        if (werr == 0) begin wa = {dclk, den}; we = {ed, een}; end
        werr++;
      end
      if (dclk && !prev) pulses++;
      prev = dclk;
      if (c != mid_c && rdata != er) begin
        if (rerr == 0) begin fa = rdata; fe = er; end
        rerr++;
      end
    end
    wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    chk(pulses == n, req, "pulse count", pulses, n);
    // R3 waveform: value printed is {dclk,enable}
    chk(werr == 0, "R3", "dclk/enable at first bad cycle", wa, we);
    chk(rerr == 0, (mode == 1) ? "R4" : "R8", "readback at first bad cycle", fa, fe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1 chk(dclk == 0 && den == 0, "R1", "dclk/enable after reset", {dclk, den}, 0);
    bus_rd(A_CNT, d); chk(d == 0, "R1", "count after reset", d, 0);
    bus_rd(A_ST, d);  chk(d == 0, "R1", "status after reset", d, 0);

    // R2 / R4 / R8 sweep, both readback modes; n = 0 is the R6 case
    for (int n = 0; n <= 20; n++) begin
      run_burst(n, 32'(n), 0, -1, (n == 0) ? "R6" : "R2");
      run_burst(n, 32'(n), 1, -1, (n == 0) ? "R6" : "R2");
    end

    // R10 large bursts and truncation of upper bits
    run_burst(256, 32'd256, 0, -1, "R10");
    run_burst(2047, 32'h7FF, 1, -1, "R10");
    run_burst(3, 32'h0001_0003, 0, -1, "R10");

    // R7 write during a burst is ignored
    run_burst(5, 32'd5, 0, 2, "R7");
    run_burst(5, 32'd5, 1, 3, "R7");
    run_burst(4, 32'd4, 0, 1, "R7");

    // R5 clearing rules; done is 1 here from the last burst
    bus_wr(A_ST, 32'h0);
    bus_rd(A_ST, d); chk(d == 1, "R5", "done after write of 0", d, 1);
    bus_wr(A_ST, 32'hFFFF_FFFE);
    bus_rd(A_ST, d); chk(d == 1, "R5", "done after write with bit0=0", d, 1);
    bus_wr(A_ST, 32'h1);
    bus_rd(A_ST, d); chk(d == 0, "R5", "done after write-one-clear", d, 0);

    // R9 undecoded addresses
    seen = 1'b0;
    bus_wr(8'h04, 32'd5);
    if (dclk || den) seen = 1'b1;
    bus_wr(8'h00, 32'd5);
    if (dclk || den) seen = 1'b1;
    bus_wr(8'h09, 32'd5);
    if (dclk || den) seen = 1'b1;
    bus_wr(8'h0D, 32'h1);
    if (dclk || den) seen = 1'b1;
    bus_wr(8'h10, 32'd7);
    if (dclk || den) seen = 1'b1;
    repeat (3) begin
      @(negedge clk); #1 if (dclk || den) seen = 1'b1;
    end
    chk(!seen, "R9", "pulses after undecoded writes", seen, 0);
    bus_rd(A_CNT, d); chk(d == 0, "R9", "count after undecoded writes", d, 0);
    bus_rd(A_ST, d);  chk(d == 0, "R9", "status after undecoded writes", d, 0);
    bus_rd(8'h04, d); chk(d == 0, "R9", "read of 0x04", d, 0);
    bus_rd(8'h0A, d); chk(d == 0, "R9", "read of 0x0A", d, 0);
    bus_wr(A_ST, 32'h1);
    bus_wr(8'h0D, 32'h1);
    bus_wr(A_CNT, 32'd0);
    bus_wr(8'h0F, 32'h1);
    bus_rd(A_ST, d); chk(d == 1, "R9", "misaligned clear ignored, status", d, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule